// File: doc/BRIEF.md
# Conditional Execution Flag Evaluator

This block decides, for every instruction, whether the instruction may execute. It holds a four-bit status flag register (negative, zero, carry, overflow). A 4-bit condition code accompanies every instruction. The block tests that code against the flags currently held and raises a permit signal when the test passes. Decode logic drives the condition code. The ALU supplies candidate flag values, and the decoder signals whether the instruction requests a flag write or belongs to the compare class.

The permit decision is purely combinational from the condition input and the registered flags. A flag write lands on the next rising clock edge, so any instruction that follows sees the new flags one cycle later. An instruction whose condition fails is treated as squashed, and it leaves the flags untouched even if it asked to write them.

Top module: `cond_exec_gate`

## Requirements
- R1: A synchronous active-high reset clears all four flags to zero at the clock edge that samples it. The flags keep their old value until that edge.
- R2: When `set_flags_i` is high and `permit_o` is high, `flags_o` equals the `alu_flags_i` value sampled at the next rising edge.
- R3: When `compare_i` is high and `permit_o` is high, the flags load from `alu_flags_i` at the next rising edge, whatever the value of `set_flags_i`.
- R4: When neither `set_flags_i` nor `compare_i` is high, the flags do not change, whatever `alu_flags_i` carries.
- R5: When `permit_o` is low, the flags do not change, even with a flag-write request present.
- R6: Condition codes 0000 to 0111 test single flags: 0000 passes on Z=1, 0001 on Z=0, 0010 on C=1, 0011 on C=0, 0100 on N=1, 0101 on N=0, 0110 on V=1 and 0111 on V=0.
- R7: The unsigned magnitude tests work as follows. Code 1000 passes when C=1 and Z=0. Code 1001 passes when C=0 or Z=1.
- R8: The signed magnitude tests work as follows. Code 1010 passes when N=V. Code 1011 passes when N differs from V. Code 1100 passes when Z=0 and N=V. Code 1101 passes when Z=1 or N differs from V.
- R9: Code 1110 always passes and code 1111 never passes.
- R10: `permit_o` follows the registered flags. A flag write takes effect on the permit decision only from the cycle after the write.
- R11: Flag bit positions are N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. This holds on both `alu_flags_i` and `flags_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition code of the current instruction |
| set_flags_i | input | 1 | Instruction requests a flag write |
| compare_i | input | 1 | Instruction is compare-class and always writes the flags |
| alu_flags_i | input | 4 | Candidate flags from the ALU, {N,Z,C,V} |
| permit_o | output | 1 | Instruction may execute |
| flags_o | output | 4 | Registered flags, {N,Z,C,V} |

## Verification
`permit_o` is due in the same cycle that `cond_i` changes, because no register lies on its path. The bench drives the condition at the falling edge and samples permit one nanosecond later, before the next rising edge. Flag results are due one rising edge after the request, so the bench drives the request at a falling edge and reads `flags_o` at the following falling edge. It samples permit once more within the request cycle to confirm the old flags still govern it. The reset check reads the flags both before and after the sampling edge.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int COND_W   = 4;
    localparam int NUM_COND = 1 << COND_W;
    localparam int NUM_PAIR = NUM_COND / 2;

    typedef enum logic [COND_W-1:0] {
        CC_ZSET  = 4'h0,
        CC_ZCLR  = 4'h1,
        CC_CSET  = 4'h2,
        CC_CCLR  = 4'h3,
        CC_NSET  = 4'h4,
        CC_NCLR  = 4'h5,
        CC_VSET  = 4'h6,
        CC_VCLR  = 4'h7,
        CC_UHI   = 4'h8,
        CC_ULS   = 4'h9,
        CC_SGE   = 4'hA,
        CC_SLT   = 4'hB,
        CC_SGT   = 4'hC,
        CC_SLE   = 4'hD,
        CC_ALWAY = 4'hE,
        CC_NEVER = 4'hF
    } cond_e;

    // Packed so that the first member lands on the most significant bit.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/cond_predicate.sv
module cond_predicate
    import cond_eval_pkg::*;
(
    input  flags_t            flags_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              pass_o
);

    // Each even code is a base test; the odd code after it is its inverse.
    logic [NUM_PAIR-1:0] base_d;
    logic [NUM_COND-1:0] all_d;

    always_comb begin
        base_d    = '0;
        base_d[0] = flags_i.z;
        base_d[1] = flags_i.c;
        base_d[2] = flags_i.n;
        base_d[3] = flags_i.v;
        base_d[4] = flags_i.c & ~flags_i.z;
        base_d[5] = (flags_i.n == flags_i.v);
        base_d[6] = ~flags_i.z & (flags_i.n == flags_i.v);
        base_d[7] = 1'b1;
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign all_d[2*p]   =  base_d[p];
        assign all_d[2*p+1] = ~base_d[p];
    end

    assign pass_o = all_d[cond_i];

endmodule

// File: rtl/cond_flag_store.sv
module cond_flag_store
    import cond_eval_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  flags_t flags_i,
    output flags_t flags_o
);

    typedef struct packed {
        flags_t flags;
    } store_s;

    store_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.flags = flags_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/cond_exec_gate.sv
module cond_exec_gate
    import cond_eval_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] cond_i,
    input  logic              set_flags_i,
    input  logic              compare_i,
    input  logic [3:0]        alu_flags_i,
    output logic              permit_o,
    output logic [3:0]        flags_o
);

    flags_t cur_q;
    flags_t alu_d;
    logic   pass_d;
    logic   load_d;

    assign alu_d = flags_t'(alu_flags_i);

    cond_predicate u_pred (
        .flags_i (cur_q),
        .cond_i  (cond_i),
        .pass_o  (pass_d)
    );

    // A squashed instruction must not disturb the flags.
    always_comb begin
        load_d = (set_flags_i | compare_i) & pass_d;
    end

    cond_flag_store u_store (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_d),
        .flags_i (alu_d),
        .flags_o (cur_q)
    );

    assign permit_o = pass_d;
    assign flags_o  = cur_q;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> flags_o == 4'b0000);

    p_setflags_load_r2: assert property (@(posedge clk) disable iff (rst)
        (set_flags_i && permit_o) |=> flags_o == $past(alu_flags_i));

    p_compare_load_r3: assert property (@(posedge clk) disable iff (rst)
        (compare_i && permit_o) |=> flags_o == $past(alu_flags_i));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!set_flags_i && !compare_i) |=> $stable(flags_o));

    p_squash_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !permit_o |=> $stable(flags_o));

    p_always_pass_r9: assert property (@(posedge clk) disable iff (rst)
        cond_i == CC_ALWAY |-> permit_o);

    p_never_pass_r9: assert property (@(posedge clk) disable iff (rst)
        cond_i == CC_NEVER |-> !permit_o);

endmodule

// File: tb/cond_exec_gate_test.sv
module cond_exec_gate_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] cond;
    logic       set_flags;
    logic       compare;
    logic [3:0] alu_flags;
    logic       permit;
    logic [3:0] flags;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cond_exec_gate uut (
        .clk         (clk),
        .rst         (rst),
        .cond_i      (cond),
        .set_flags_i (set_flags),
        .compare_i   (compare),
        .alu_flags_i (alu_flags),
        .permit_o    (permit),
        .flags_o     (flags)
    );

    // Expected permit from the requirement text; flags are {N,Z,C,V} (R11).
    function automatic logic expect_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Load flags through a compare under the always-pass code.
    task automatic load_flags(input logic [3:0] f);
        @(negedge clk);
        cond = 4'hE; compare = 1'b1; set_flags = 1'b0; alu_flags = f;
        @(negedge clk);
        compare = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cond = 4'hE; set_flags = 1'b0; compare = 1'b0; alu_flags = 4'h0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset value", flags, 4'h0);

        // Exhaustive sweep: every flag value against every condition code.
        for (int f = 0; f < 16; f++) begin
            load_flags(4'(f));
            check("R3 compare load / R11 order", flags, 4'(f));
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                cond = 4'(c);
                #1;
                if (c < 8)
                    check("R6 single-flag test", {3'b0, permit}, {3'b0, expect_pass(4'(c), 4'(f))});
                else if (c < 10)
                    check("R7 unsigned test", {3'b0, permit}, {3'b0, expect_pass(4'(c), 4'(f))});
                else if (c < 14)
                    check("R8 signed test", {3'b0, permit}, {3'b0, expect_pass(4'(c), 4'(f))});
                else
                    check("R9 always/never", {3'b0, permit}, {3'b0, expect_pass(4'(c), 4'(f))});
            end
            check("R4 no update during sweep", flags, 4'(f));
        end

        // R2 and R10: set-flags write, old flags govern permit in the write cycle.
        load_flags(4'hA);
        @(negedge clk);
        cond = 4'h4; set_flags = 1'b1; alu_flags = 4'h4;
        #1;
        check("R10 permit uses old flags", {3'b0, permit}, 4'h1);
        @(negedge clk);
        set_flags = 1'b0;
        check("R2 set-flags load", flags, 4'h4);
        #1;
        check("R10 permit uses new flags", {3'b0, permit}, 4'h0);

        // R4: idle cycle ignores alu flags.
        @(negedge clk);
        cond = 4'hE; alu_flags = 4'hF;
        @(negedge clk);
        check("R4 idle hold", flags, 4'h4);

        // R5: squashed instruction with set-flags, then with compare.
        @(negedge clk);
        cond = 4'h1; set_flags = 1'b1; alu_flags = 4'hB;
        @(negedge clk);
        check("R5 squashed set-flags", flags, 4'h4);
        set_flags = 1'b0; compare = 1'b1; alu_flags = 4'h9;
        @(negedge clk);
        compare = 1'b0;
        check("R5 squashed compare", flags, 4'h4);

        // R3: compare and set-flags together under a passing code.
        @(negedge clk);
        cond = 4'h0; compare = 1'b1; set_flags = 1'b1; alu_flags = 4'h3;
        @(negedge clk);
        compare = 1'b0; set_flags = 1'b0;
        check("R3 compare with set-flags", flags, 4'h3);

        // R1: reset is synchronous.
        @(negedge clk);
        cond = 4'hE; rst = 1'b1;
        #1;
        check("R1 no clear before edge", flags, 4'h3);
        @(negedge clk);
        rst = 1'b0;
        check("R1 clear at edge", flags, 4'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule